// File: doc/BRIEF.md
# Static/Dynamic Slot Media Access Scheduler

This block sequences the transmit side of a time-triggered bus controller, one macrotick at a time. Every communication cycle has three phases in a fixed order. The first is a static segment made of equal-length slots. The second is a dynamic segment measured in minislots. The third is a short network idle time. After that a new cycle begins with the cycle number incremented. The block keeps the cycle, slot and minislot counters. For each slot it checks whether the send buffer tied to that slot number holds a frame.

When a frame goes out, the scheduler drives a frame-start code on the bus status output for one macrotick. It then drives a busy code for the rest of the frame length and returns to the idle code. On the same clock it pulses a take strobe that carries the slot number, so the buffer bank can clear that entry.

The configuration inputs are assumed stable while the scheduler runs. They are:
- the static slot length and count,
- the minislot length and count,
- the idle length,
- the last slot number allowed to transmit.

Startup, clock alignment and error handling are not part of this block.

Top module: `msched_top`

## Requirements
- R1: After reset, the segment is static (code 0), the slot is 1, and the cycle and minislot counters are 0. The bus status is idle (code 00) and the take strobe is low.
- R2: State advances only on clocks where `mt_en` is high. While `mt_en` is low, the counters, segment and bus status hold their values.
- R3: The segments run in the order static (0), dynamic (1), idle (2), and then a new cycle begins. A cycle lasts st_num*st_len + ms_num*ms_len + nit_len macroticks. The cycle counter increments by one at the start of each new cycle.
- R4: A static frame starts AP macroticks after its slot begins (AP defaults to 1). It starts only if its buffer is valid and its length is at most st_len-AP.
- R5: A static slot lasts exactly st_len macroticks, whether or not a frame is sent in it.
- R6: A dynamic slot with no frame takes one minislot, and the slot counter then advances by one.
- R7: A dynamic frame starts on the first macrotick of its slot. The slot lasts ceil(len/ms_len) minislots, with a minimum of one.
- R8: A dynamic frame is sent only if its length is at most the number of macroticks left in the dynamic segment. Otherwise the slot is handled as an empty slot.
- R9: After the slot numbered cfg_last_slot ends, no further slot starts. The slot counter holds its value and the minislots continue until the configured count is reached.
- R10: Bus status codes: frame-start is 01 and is driven for the first macrotick of a frame. Busy is 10 and is driven for the following len-1 macroticks. Idle is 00 at all other times.
- R11: The take strobe is high for exactly one clock. It rises on the same edge where frame-start appears, and `take_slot` equals the slot number of that frame.
- R12: Slot numbering starts at 1 each cycle. The first dynamic slot is st_num+1. Buffer bit i-1 (and length lane i-1) belongs to slot i.
- R13: A static frame longer than st_len-AP is not sent, and its slot passes with the bus idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_en | input | 1 | Macrotick enable; one macrotick elapses per high clock |
| cfg_st_len | input | LW | Static slot length in macroticks |
| cfg_st_num | input | SW | Number of static slots |
| cfg_ms_len | input | LW | Minislot length in macroticks |
| cfg_ms_num | input | MW | Minislots in the dynamic segment |
| cfg_nit_len | input | LW | Network idle time in macroticks |
| cfg_last_slot | input | SW | Highest slot number that may transmit |
| buf_valid | input | NBUF | Send-buffer full flags, bit i-1 for slot i |
| buf_len | input | NBUF*LW | Frame lengths in macroticks, lane i-1 for slot i |
| bus_st | output | 2 | Bus status: 00 idle, 01 frame start, 10 busy |
| take_stb | output | 1 | One-clock buffer take/clear strobe |
| take_slot | output | SW | Slot number carried with the strobe |
| seg | output | 2 | Current segment: 0 static, 1 dynamic, 2 idle |
| slot_no | output | SW | Current slot number |
| minislot_no | output | MW | Minislot index within the dynamic segment |
| cycle_no | output | CW | Communication cycle counter |

## Verification
The hardest state to reach from the ports is the dynamic segment at its edges. One case is a frame whose length exactly equals, or just exceeds, the macroticks left when its slot opens. The other is the idle tail that follows the last permitted slot. To get there, the bench holds the configuration fixed so that every dynamic slot opens at a predictable macrotick. It then chooses frame lengths at that exact remaining room and one macrotick above it. It also pairs a frame that will be rejected with a later frame, which shows that the rejected slot used only a single minislot. The bench acts as the buffer bank: it clears entries on the strobe and records the macrotick of every frame start and every busy macrotick.

// File: rtl/msched_pkg.sv
package msched_pkg;

  typedef enum logic [1:0] {
    SEG_ST  = 2'd0,
    SEG_DY  = 2'd1,
    SEG_NIT = 2'd2
  } seg_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'b00,
    BUS_SOF  = 2'b01,
    BUS_DATA = 2'b10
  } bus_e;

endpackage

// File: rtl/msched_pick.sv
module msched_pick #(
  parameter int NBUF = 8,
  parameter int SW   = 4,
  parameter int LW   = 8
) (
  input  logic [SW-1:0]      slot,
  input  logic [NBUF-1:0]    valid,
  input  logic [NBUF*LW-1:0] lens,
  output logic               hit,
  output logic [LW-1:0]      len
);

  logic [NBUF-1:0] match;
  logic [LW-1:0]   lane [NBUF];

  // one comparator per buffer: lane i serves slot i+1
  for (genvar i = 0; i < NBUF; i++) begin : g_lane
    assign match[i] = (slot == SW'(i + 1)) && valid[i];
    assign lane[i]  = match[i] ? lens[i*LW +: LW] : '0;
  end

  always_comb begin
    hit = |match;
    len = '0;
    for (int i = 0; i < NBUF; i++) len = len | lane[i];
  end

endmodule

// File: rtl/msched_timebase.sv
module msched_timebase
  import msched_pkg::*;
#(
  parameter int SW = 4,
  parameter int LW = 8,
  parameter int MW = 8,
  parameter int CW = 8,
  parameter int AP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mt_en,
  input  logic [LW-1:0] cfg_st_len,
  input  logic [SW-1:0] cfg_st_num,
  input  logic [LW-1:0] cfg_ms_len,
  input  logic [MW-1:0] cfg_ms_num,
  input  logic [LW-1:0] cfg_nit_len,
  input  logic [SW-1:0] cfg_last_slot,
  input  logic          sel_valid,
  input  logic [LW-1:0] sel_len,
  output logic [SW-1:0] nx_slot,
  output logic          fire,
  output seg_e          seg_o,
  output logic [SW-1:0] slot_o,
  output logic [LW-1:0] off_o,
  output logic [MW-1:0] ms_o,
  output logic [CW-1:0] cycle_o
);

  localparam int DW = LW + MW;

  // macroticks in the whole dynamic segment
  function automatic logic [DW-1:0] seg_room(input logic [MW-1:0] n, input logic [LW-1:0] l);
    return DW'(n) * DW'(l);
  endfunction

  // static frame fits between the action point and the slot end
  function automatic logic fits_static(input logic [LW-1:0] l, input logic [LW-1:0] slen);
    return ({1'b0, l} + (LW+1)'(AP)) <= {1'b0, slen};
  endfunction

  // a dynamic slot may close at this minislot boundary
  function automatic logic slot_done(input logic [DW-1:0] elapsed, input logic [LW-1:0] l);
    return (elapsed + DW'(1)) >= DW'(l);
  endfunction

  seg_e          seg, n_seg;
  logic [SW-1:0] slot, n_slot;
  logic [LW-1:0] off, n_off, ms_off, n_msoff, nit_off, n_nit, dlen;
  logic [MW-1:0] ms, n_ms;
  logic [DW-1:0] dleft, n_dleft, dmt, n_dmt;
  logic [CW-1:0] cycle, n_cycle;
  logic          tail, n_tail, nx_dstart;
  logic          st_go, dy_go;

  always_comb begin
    n_seg = seg;  n_slot = slot;  n_off = off;  n_ms = ms;  n_msoff = ms_off;
    n_dleft = dleft;  n_dmt = dmt;  n_tail = tail;  n_nit = nit_off;  n_cycle = cycle;
    nx_dstart = 1'b0;
    unique case (seg)
      SEG_ST: begin
        if (off < cfg_st_len - LW'(1)) begin
          n_off = off + LW'(1);
        end else if (slot < cfg_st_num) begin
          n_slot = slot + SW'(1);
          n_off  = '0;
        end else begin
          n_seg   = SEG_DY;
          n_off   = '0;
          n_ms    = '0;
          n_msoff = '0;
          n_dmt   = '0;
          n_dleft = seg_room(cfg_ms_num, cfg_ms_len);
          if (slot < cfg_last_slot) begin
            n_slot    = slot + SW'(1);
            nx_dstart = 1'b1;
            n_tail    = 1'b0;
          end else begin
            n_tail = 1'b1;
          end
        end
      end
      SEG_DY: begin
        n_dleft = dleft - DW'(1);
        n_dmt   = dmt + DW'(1);
        if (ms_off < cfg_ms_len - LW'(1)) begin
          n_msoff = ms_off + LW'(1);
        end else begin
          n_msoff = '0;
          if (ms + MW'(1) >= cfg_ms_num) begin
            n_seg = SEG_NIT;
            n_nit = '0;
          end else begin
            n_ms = ms + MW'(1);
            if (!tail && slot_done(dmt, dlen)) begin
              n_dmt = '0;
              if (slot < cfg_last_slot) begin
                n_slot    = slot + SW'(1);
                nx_dstart = 1'b1;
              end else begin
                n_tail = 1'b1;
              end
            end
          end
        end
      end
      default: begin
        if (nit_off < cfg_nit_len - LW'(1)) begin
          n_nit = nit_off + LW'(1);
        end else begin
          n_seg   = SEG_ST;
          n_slot  = SW'(1);
          n_off   = '0;
          n_cycle = cycle + CW'(1);
        end
      end
    endcase
  end

  assign st_go   = (seg == SEG_ST) && (n_seg == SEG_ST) && (n_off == LW'(AP)) &&
                   fits_static(sel_len, cfg_st_len);
  assign dy_go   = nx_dstart && (DW'(sel_len) <= n_dleft);
  assign fire    = mt_en && sel_valid && (st_go || dy_go);
  assign nx_slot = n_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg <= SEG_ST;  slot <= SW'(1);  off <= '0;  ms <= '0;  ms_off <= '0;
      dleft <= '0;  dmt <= '0;  dlen <= '0;  tail <= 1'b0;  nit_off <= '0;  cycle <= '0;
    end else if (mt_en) begin
      seg <= n_seg;  slot <= n_slot;  off <= n_off;  ms <= n_ms;  ms_off <= n_msoff;
      dleft <= n_dleft;  dmt <= n_dmt;  tail <= n_tail;  nit_off <= n_nit;  cycle <= n_cycle;
      if (nx_dstart) dlen <= (sel_valid && dy_go) ? sel_len : '0;
    end
  end

  assign seg_o   = seg;
  assign slot_o  = slot;
  assign off_o   = off;
  assign ms_o    = ms;
  assign cycle_o = cycle;

  // R3: entering the static segment from idle bumps the cycle counter by one
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_ST && $past(seg) == SEG_NIT) |-> (cycle == CW'($past(cycle) + 1'b1)));

  // R5: static offset and slot number stay inside the configured static segment
  a_r5_static_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_ST) |-> ((off < cfg_st_len) && (slot >= SW'(1)) && (slot <= cfg_st_num)));

  // R6: minislot index stays below the configured count
  a_r6_ms_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_DY) |-> (ms < cfg_ms_num));

  // R9: once in the tail, the slot number no longer moves
  a_r9_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_DY && tail && mt_en) |=> (slot == $past(slot)));

  // R2: no macrotick, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mt_en) |=> ($stable(seg) && $stable(slot) && $stable(off) && $stable(ms)));

endmodule

// File: rtl/msched_tx.sv
module msched_tx
  import msched_pkg::*;
#(
  parameter int SW = 4,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mt_en,
  input  logic          fire,
  input  logic [LW-1:0] len,
  input  logic [SW-1:0] slot,
  output bus_e          bus,
  output logic          stb,
  output logic [SW-1:0] stb_slot
);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus      <= BUS_IDLE;
      left     <= '0;
      stb      <= 1'b0;
      stb_slot <= '0;
    end else begin
      stb <= 1'b0;
      if (fire) begin
        bus      <= BUS_SOF;
        left     <= (len == '0) ? '0 : len - LW'(1);
        stb      <= 1'b1;
        stb_slot <= slot;
      end else if (mt_en) begin
        if (left != '0) begin
          bus  <= BUS_DATA;
          left <= left - LW'(1);
        end else begin
          bus <= BUS_IDLE;
        end
      end
    end
  end

  // R11: the strobe only accompanies a frame-start code
  a_r11_stb_sof: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (bus == BUS_SOF));

  // R10: frame-start lasts one macrotick unless a new frame starts
  a_r10_sof_once: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == BUS_SOF && mt_en && !fire) |=> (bus != BUS_SOF));

endmodule

// File: rtl/msched_top.sv
module msched_top
  import msched_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int SW   = 4,
  parameter int LW   = 8,
  parameter int MW   = 8,
  parameter int CW   = 8,
  parameter int AP   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mt_en,
  input  logic [LW-1:0]      cfg_st_len,
  input  logic [SW-1:0]      cfg_st_num,
  input  logic [LW-1:0]      cfg_ms_len,
  input  logic [MW-1:0]      cfg_ms_num,
  input  logic [LW-1:0]      cfg_nit_len,
  input  logic [SW-1:0]      cfg_last_slot,
  input  logic [NBUF-1:0]    buf_valid,
  input  logic [NBUF*LW-1:0] buf_len,
  output logic [1:0]         bus_st,
  output logic               take_stb,
  output logic [SW-1:0]      take_slot,
  output logic [1:0]         seg,
  output logic [SW-1:0]      slot_no,
  output logic [MW-1:0]      minislot_no,
  output logic [CW-1:0]      cycle_no
);

  logic [SW-1:0] nx_slot;
  logic          sel_valid, fire;
  logic [LW-1:0] sel_len, off_w;
  seg_e          seg_w;
  bus_e          bus_w;

  msched_pick #(.NBUF(NBUF), .SW(SW), .LW(LW)) u_pick (
    .slot(nx_slot), .valid(buf_valid), .lens(buf_len), .hit(sel_valid), .len(sel_len)
  );

  msched_timebase #(.SW(SW), .LW(LW), .MW(MW), .CW(CW), .AP(AP)) u_tb (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en),
    .cfg_st_len(cfg_st_len), .cfg_st_num(cfg_st_num), .cfg_ms_len(cfg_ms_len),
    .cfg_ms_num(cfg_ms_num), .cfg_nit_len(cfg_nit_len), .cfg_last_slot(cfg_last_slot),
    .sel_valid(sel_valid), .sel_len(sel_len), .nx_slot(nx_slot), .fire(fire),
    .seg_o(seg_w), .slot_o(slot_no), .off_o(off_w), .ms_o(minislot_no), .cycle_o(cycle_no)
  );

  msched_tx #(.SW(SW), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .fire(fire), .len(sel_len), .slot(nx_slot),
    .bus(bus_w), .stb(take_stb), .stb_slot(take_slot)
  );

  assign seg    = seg_w;
  assign bus_st = bus_w;

  // R11: strobe slot matches the slot counter of the timebase
  a_r11_stb_slot: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> (take_slot == slot_no));

  // R4: a static frame starts exactly at the action point
  a_r4_action_point: assert property (@(posedge clk) disable iff (!rst_n)
    (take_stb && seg_w == SEG_ST) |-> (off_w == LW'(AP)));

endmodule

// File: tb/sim_msched_top.sv
`timescale 1ns/1ps
module sim_msched_top;
  localparam int NBUF = 8, SW = 4, LW = 8, MW = 8, CW = 8;
  localparam int CYC = 182;
  localparam logic [15:0] NONE = 16'hFFFF;
  // {req, slot, len, expected start macrotick}
  localparam logic [39:0] VEC [9] = '{
    {8'd4,  8'd1, 8'd5,   16'd1},
    {8'd4,  8'd3, 8'd9,   16'd21},
    {8'd13, 8'd2, 8'd10,  NONE},
    {8'd7,  8'd4, 8'd12,  16'd30},
    {8'd6,  8'd5, 8'd7,   16'd35},
    {8'd8,  8'd6, 8'd150, NONE},
    {8'd8,  8'd6, 8'd140, 16'd40},
    {8'd9,  8'd7, 8'd3,   NONE},
    {8'd12, 8'd2, 8'd4,   16'd11}
  };

  logic clk = 0, rst_n = 0, mt_en = 0;
  logic [NBUF-1:0]    buf_valid = '0;
  logic [NBUF*LW-1:0] buf_len = '0;
  logic [LW-1:0] cfg_st_len = 8'd10, cfg_ms_len = 8'd5, cfg_nit_len = 8'd2;
  logic [SW-1:0] cfg_st_num = 4'd3, cfg_last_slot = 4'd6;
  logic [MW-1:0] cfg_ms_num = 8'd30;
  logic [1:0] bus_st, seg;
  logic take_stb;
  logic [SW-1:0] take_slot, slot_no;
  logic [MW-1:0] minislot_no;
  logic [CW-1:0] cycle_no;

  int checks = 0, errors = 0, mt = 0, cur = 0;
  int st_time [16];
  int occ [16];
  int nbusy [16];
  bit sof_ok;

  always #4 clk = ~clk;

  msched_top #(.NBUF(NBUF), .SW(SW), .LW(LW), .MW(MW), .CW(CW), .AP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en),
    .cfg_st_len(cfg_st_len), .cfg_st_num(cfg_st_num), .cfg_ms_len(cfg_ms_len),
    .cfg_ms_num(cfg_ms_num), .cfg_nit_len(cfg_nit_len), .cfg_last_slot(cfg_last_slot),
    .buf_valid(buf_valid), .buf_len(buf_len), .bus_st(bus_st), .take_stb(take_stb),
    .take_slot(take_slot), .seg(seg), .slot_no(slot_no), .minislot_no(minislot_no),
    .cycle_no(cycle_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string rname(input int r);
    case (r)
      4: return "R4";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  12: return "R12"; 13: return "R13";
      default: return "R?";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 0; mt_en = 0; buf_valid = '0; buf_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mt = 0; cur = 0; sof_ok = 1;
    for (int i = 0; i < 16; i++) begin st_time[i] = -1; occ[i] = 0; nbusy[i] = 0; end
  endtask

  task automatic set_buf(input int s, input int l);
    buf_valid[s-1] = 1'b1;
    buf_len[(s-1)*LW +: LW] = LW'(l);
  endtask

  // one macrotick; samples at the falling edge after it, acts as buffer bank
  task automatic tick();
    @(negedge clk) mt_en = 1;
    @(negedge clk) mt_en = 0;
    mt++;
    if (take_stb) begin
      cur = int'(take_slot);
      st_time[cur] = mt;
      if (bus_st != 2'b01) sof_ok = 0;
      buf_valid[cur-1] = 1'b0;
    end
    if (cur > 0 && bus_st != 2'b00) occ[cur]++;
    if (cur > 0 && bus_st == 2'b10) nbusy[cur]++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // table walk: one frame per run, full cycle each
    for (int v = 0; v < 9; v++) begin
      int r, s, l, e;
      r = int'(VEC[v][39:32]); s = int'(VEC[v][31:24]);
      l = int'(VEC[v][23:16]); e = int'(VEC[v][15:0]);
      do_reset();
      set_buf(s, l);
      for (int k = 0; k < CYC; k++) tick();
      if (VEC[v][15:0] == NONE) begin
        chk(st_time[s] == -1, rname(r), st_time[s], -1);
        chk(occ[s] == 0, "R10", occ[s], 0);
      end else begin
        chk(st_time[s] == e, rname(r), st_time[s], e);
        chk(occ[s] == l && nbusy[s] == l - 1 && sof_ok, "R10", occ[s], l);
      end
      chk(seg == 2'd0 && cycle_no == 8'd1 && slot_no == 4'd1, "R3", int'(cycle_no), 1);
    end

    // R1: reset state
    do_reset();
    chk(seg == 2'd0 && slot_no == 4'd1, "R1", int'(slot_no), 1);
    chk(cycle_no == 0 && minislot_no == 0 && bus_st == 2'b00 && take_stb == 0, "R1",
        int'(bus_st), 0);

    // R2 stall, R5 full-length empty static slots, R12 numbering into dynamic
    for (int k = 0; k < 5; k++) tick();
    begin
      logic [SW-1:0] s0; logic [1:0] g0;
      s0 = slot_no; g0 = seg;
      repeat (20) @(negedge clk);
      chk(slot_no == s0 && seg == g0 && mt == 5, "R2", int'(slot_no), int'(s0));
    end
    for (int k = 0; k < 4; k++) tick();
    chk(slot_no == 4'd1, "R5", int'(slot_no), 1);
    tick();
    chk(slot_no == 4'd2, "R5", int'(slot_no), 2);
    while (mt < 30) tick();
    chk(slot_no == 4'd4 && seg == 2'd1, "R12", int'(slot_no), 4);

    // R7/R6/R9: three dynamic frames, then the idle tail
    do_reset();
    set_buf(4, 12); set_buf(5, 3); set_buf(6, 1);
    while (mt < CYC) begin
      tick();
      if (mt == 100) chk(seg == 2'd1 && slot_no == 4'd6 && minislot_no == 8'd14, "R9",
                         int'(minislot_no), 14);
      if (mt == 181) chk(seg == 2'd2, "R3", int'(seg), 2);
    end
    chk(st_time[4] == 30, "R7", st_time[4], 30);
    chk(st_time[5] == 45, "R7", st_time[5], 45);
    chk(st_time[6] == 50, "R6", st_time[6], 50);

    // R8: rejected frame consumes one minislot only
    do_reset();
    set_buf(5, 150); set_buf(6, 3);
    for (int k = 0; k < 60; k++) tick();
    chk(st_time[5] == -1, "R8", st_time[5], -1);
    chk(st_time[6] == 40, "R8", st_time[6], 40);

    // R11/R10: strobe width and code sequence
    do_reset();
    set_buf(1, 2);
    tick();
    chk(take_stb == 1 && take_slot == 4'd1 && bus_st == 2'b01, "R11", int'(take_slot), 1);
    @(negedge clk);
    chk(take_stb == 0, "R11", int'(take_stb), 0);
    tick();
    chk(bus_st == 2'b10, "R10", int'(bus_st), 2);
    tick();
    chk(bus_st == 2'b00, "R10", int'(bus_st), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule